// File: doc/BRIEF.md
# Bootloader Transfer Block Checker

This block sits behind a UART receiver in a serial boot loader. It takes the received byte stream, frames it into transfer blocks and judges each one. A block starts with a type byte, carries a data area and ends with a checksum byte. The checksum byte is the XOR of the type byte and every data-area byte. For each complete block the checker returns a single response byte for the transmitter. Either that byte acknowledges the block, or it names why the block was refused.

A header block selects a working mode. The checker records the mode number and five mode parameter bytes, and it tracks which block kinds the selected mode allows next. The data area of an accepted data block is held in an internal buffer until its checksum is known to be good. Only then is it replayed on a byte output, one byte per clock. A block that stalls part way through is dropped after a configurable number of idle cycles.

Top module: `bsl_block_checker`

## Requirements
- R1: The type byte (first byte of a block) is decoded as 0x00 header, 0x01 data and 0x02 end-of-transmission. Any other type value is answered with 0xFF in the cycle after that byte. No further bytes are consumed for it, and the next byte is taken as a new type byte.
- R2: A header is 8 bytes: type, mode number, five mode bytes, checksum. When a header is acknowledged, `mode` takes the mode number and `mode_data[8*i+7:8*i]` takes mode byte i (i = 0 is the first received). Both outputs change at no other time.
- R3: The checksum byte must equal the XOR of the type byte and all data-area bytes. Otherwise the response is 0xFE.
- R4: Exactly one response is given per framed block, with `rsp_valid` high for one cycle, in the cycle after the final byte's `rx_valid`. Its code is one of 0x55 acknowledge, 0xFF type or sequence error, 0xFE checksum error, 0xFD protection error. When several apply, the priority is sequence, then checksum, then protection.
- R5: The following are sequence errors (0xFF): a data or end block while waiting for a header, a header while a download or erase is in progress, and a data block while an erase is in progress. After a 0xFF or 0xFE response the sequence state and the mode outputs are unchanged.
- R6: The data area of data and end blocks is 128 bytes when the recorded mode is 2. Otherwise it is `data_len` as sampled with the type byte, with 0 or values above 128 taken as 128.
- R7: While `prot_active` is high, a valid header for a mode other than 1 or 3 is answered with 0xFD. The mode outputs are left unchanged and the checker waits for a header.
- R8: An acknowledged header for mode 0 or 2 enters the download state, in which data and end blocks are allowed. Mode 4 enters the erase state, in which only an end block is allowed. Any other mode keeps waiting for a header. An acknowledged end block returns to waiting for a header.
- R9: The data area of an acknowledged data block appears in order on `out_byte`, one byte per cycle with `out_valid` high. It starts in the same cycle as the acknowledge. Rejected blocks produce no output.
- R10: If no byte arrives for TIMEOUT cycles while a block is partly received, the partial block is discarded without a response, and the next byte is a type byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| data_len | input | LW | Data-area length for data and end blocks |
| prot_active | input | 1 | Memory protection is installed |
| rsp_valid | output | 1 | Response byte strobe |
| rsp_code | output | 8 | Response byte |
| mode | output | 8 | Mode number of the last acknowledged header |
| mode_data | output | 40 | Five mode bytes of the last acknowledged header |
| out_valid | output | 1 | Forwarded data byte strobe |
| out_byte | output | 8 | Forwarded data byte |

## Verification
The hardest cases to reach are error responses that must leave the sequence state untouched. The clearest is a corrupted block arriving while an erase is pending: a later block is the only way to show that the state did not move. The stimulus runs a bench-side sequence model. It draws block kinds with a bias so that every state meets both legal and illegal successors, corrupts roughly one checksum in six, and raises protection at random. Each response then exposes any earlier state slip. Directed cases add the stalled-block timeout, the length clamps and the fixed 128-byte length in mode 2.

// File: rtl/bsl_block_checker.sv
module bsl_block_checker #(
  parameter int MAXLEN  = 128,
  parameter int TIMEOUT = 200,
  localparam int LW = $clog2(MAXLEN + 1),
  localparam int AW = $clog2(MAXLEN),
  localparam int TW = $clog2(TIMEOUT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [7:0]    rx_byte,
  input  logic [LW-1:0] data_len,
  input  logic          prot_active,
  output logic          rsp_valid,
  output logic [7:0]    rsp_code,
  output logic [7:0]    mode,
  output logic [39:0]   mode_data,
  output logic          out_valid,
  output logic [7:0]    out_byte
);
  localparam logic [7:0] ACK = 8'h55, ESEQ = 8'hFF, ECHK = 8'hFE, EPROT = 8'hFD;
  localparam logic [LW-1:0] FULL = LW'(MAXLEN);

  typedef enum logic [1:0] {S_HDR, S_DL, S_ERA} seq_t;
  typedef enum logic [1:0] {P_TYPE, P_BODY, P_CSUM} ph_t;

  seq_t          seq_q;
  ph_t           ph_q;
  logic [1:0]    btype;
  logic [LW-1:0] cnt, blen, didx, dlen;
  logic [7:0]    acc;
  logic [7:0]    hbuf [6];
  logic [7:0]    mem  [MAXLEN];
  logic [TW-1:0] tcnt;
  logic          dact;

  logic [LW-1:0] eff_len;
  logic          seq_ok, sum_ok, prot_blk;
  logic [7:0]    verdict;

  assign eff_len = (mode == 8'd2) ? FULL :
                   (data_len == '0 || data_len > FULL) ? FULL : data_len;

  always_comb begin
    case (btype)
      2'd0:    seq_ok = (seq_q == S_HDR);
      2'd1:    seq_ok = (seq_q == S_DL);
      default: seq_ok = (seq_q == S_DL) || (seq_q == S_ERA);
    endcase
  end

  assign sum_ok   = (acc == rx_byte);
  assign prot_blk = (btype == 2'd0) && prot_active && hbuf[0] != 8'd1 && hbuf[0] != 8'd3;
  assign verdict  = !seq_ok ? ESEQ : !sum_ok ? ECHK : prot_blk ? EPROT : ACK;

  assign out_valid = dact;
  assign out_byte  = mem[didx[AW-1:0]];

  always_ff @(posedge clk) begin
    if (rx_valid && ph_q == P_BODY) begin
      if (btype == 2'd0) hbuf[cnt[2:0]] <= rx_byte;
      else if (btype == 2'd1) mem[cnt[AW-1:0]] <= rx_byte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq_q     <= S_HDR;
      ph_q      <= P_TYPE;
      btype     <= '0;
      cnt       <= '0;
      blen      <= '0;
      acc       <= '0;
      tcnt      <= '0;
      rsp_valid <= 1'b0;
      rsp_code  <= '0;
      mode      <= '0;
      mode_data <= '0;
      dact      <= 1'b0;
      didx      <= '0;
      dlen      <= '0;
    end else begin
      rsp_valid <= 1'b0;

      if (dact) begin
        didx <= didx + 1'b1;
        if (didx == dlen - 1'b1) dact <= 1'b0;
      end

      if (ph_q == P_TYPE || rx_valid) tcnt <= '0;
      else if (tcnt == TW'(TIMEOUT - 1)) begin
        tcnt <= '0;
        ph_q <= P_TYPE;
      end else tcnt <= tcnt + 1'b1;

      if (rx_valid) begin
        case (ph_q)
          P_TYPE: begin
            if (rx_byte <= 8'd2) begin
              btype <= rx_byte[1:0];
              blen  <= (rx_byte == 8'd0) ? LW'(6) : eff_len;
              acc   <= rx_byte;
              cnt   <= '0;
              ph_q  <= P_BODY;
            end else begin
              rsp_valid <= 1'b1;
              rsp_code  <= ESEQ;
            end
          end
          P_BODY: begin
            acc <= acc ^ rx_byte;
            cnt <= cnt + 1'b1;
            if (cnt == blen - 1'b1) ph_q <= P_CSUM;
          end
          default: begin
            ph_q      <= P_TYPE;
            rsp_valid <= 1'b1;
            rsp_code  <= verdict;
            if (verdict == ACK) begin
              case (btype)
                2'd0: begin
                  mode      <= hbuf[0];
                  mode_data <= {hbuf[5], hbuf[4], hbuf[3], hbuf[2], hbuf[1]};
                  if (hbuf[0] == 8'd0 || hbuf[0] == 8'd2) seq_q <= S_DL;
                  else if (hbuf[0] == 8'd4) seq_q <= S_ERA;
                  else seq_q <= S_HDR;
                end
                2'd1: begin
                  dact <= 1'b1;
                  didx <= '0;
                  dlen <= blen;
                end
                default: seq_q <= S_HDR;
              endcase
            end else if (verdict == EPROT) seq_q <= S_HDR;
          end
        endcase
      end
    end
  end

  // R4
  rsp_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(rx_valid));

  // R4
  rsp_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_code == ACK || rsp_code == ESEQ || rsp_code == ECHK || rsp_code == EPROT));

  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(mode) || !$stable(mode_data)) |-> (rsp_valid && rsp_code == ACK));

  // R9
  out_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (rsp_valid && rsp_code == ACK));

  // R10
  timer_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tcnt < TW'(TIMEOUT));

  // R7
  prot_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code == EPROT) |-> seq_q == S_HDR);
endmodule

// File: tb/tb_bsl_block_checker.sv
module tb_bsl_block_checker;
  localparam int TMO = 200;
  logic clk = 0, rst_n = 0, rx_valid = 0, prot_active = 0;
  logic [7:0] rx_byte = 0, data_len = 8'd16;
  logic rsp_valid, out_valid;
  logic [7:0] rsp_code, mode, out_byte;
  logic [39:0] mode_data;

  bsl_block_checker #(.MAXLEN(128), .TIMEOUT(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .data_len(data_len), .prot_active(prot_active), .rsp_valid(rsp_valid),
    .rsp_code(rsp_code), .mode(mode), .mode_data(mode_data),
    .out_valid(out_valid), .out_byte(out_byte));

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] rq[$], oq[$];
  int m_st = 0;
  logic [7:0] m_mode = 0;
  logic [39:0] m_mdata = 0;

  always @(negedge clk) begin
    if (rsp_valid) rq.push_back(rsp_code);
    if (out_valid) oq.push_back(out_byte);
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send_byte(logic [7:0] b);
    @(negedge clk);
    rx_valid = 1; rx_byte = b;
    @(negedge clk);
    rx_valid = 0;
    repeat ($urandom % 3) @(negedge clk);
  endtask

  function automatic int blk_len(logic [7:0] dl);
    if (m_mode == 8'd2) return 128;
    if (dl == 0 || dl > 128) return 128;
    return dl;
  endfunction

  task automatic send_blk(logic [7:0] typ, logic [7:0] md, bit bad);
    logic [7:0] pl[$];
    logic [7:0] ck, exp;
    bit seqok;
    string tag;
    int n;
    pl.delete();
    if (typ == 0) begin
      pl.push_back(md);
      for (int i = 0; i < 5; i++) pl.push_back(8'($urandom));
    end else begin
      n = blk_len(data_len);
      for (int i = 0; i < n; i++) pl.push_back(8'($urandom));
    end
    ck = typ;
    foreach (pl[i]) ck ^= pl[i];
    if (bad) ck ^= 8'(1 << ($urandom % 8));
    rq.delete(); oq.delete();
    send_byte(typ);
    foreach (pl[i]) send_byte(pl[i]);
    send_byte(ck);
    repeat ((typ == 1) ? 135 : 3) @(negedge clk);

    seqok = (typ == 0) ? (m_st == 0) : (typ == 1) ? (m_st == 1) : (m_st != 0);
    if (!seqok) begin exp = 8'hFF; tag = "R5"; end
    else if (bad) begin exp = 8'hFE; tag = "R3"; end
    else if (typ == 0 && prot_active && md != 1 && md != 3) begin exp = 8'hFD; tag = "R7"; end
    else begin exp = 8'h55; tag = "R8"; end
    chk(rq.size() == 1, "R4", "response count", rq.size(), 1);
    if (rq.size() > 0) chk(rq[0] == exp, tag, "response code", rq[0], exp);

    if (exp == 8'h55 && typ == 1) begin
      chk(oq.size() == pl.size(), "R6", "forwarded length", oq.size(), pl.size());
      if (oq.size() == pl.size())
        foreach (pl[i]) if (oq[i] !== pl[i]) begin
          chk(0, "R9", "forwarded byte", oq[i], pl[i]);
          break;
        end
    end else chk(oq.size() == 0, "R9", "no forwarding", oq.size(), 0);

    if (exp == 8'h55) begin
      if (typ == 0) begin
        m_mode = md;
        m_mdata = {pl[5], pl[4], pl[3], pl[2], pl[1]};
        m_st = (md == 0 || md == 2) ? 1 : (md == 4) ? 2 : 0;
      end else if (typ == 2) m_st = 0;
    end else if (exp == 8'hFD) m_st = 0;
    chk(mode == m_mode, "R2", "mode", mode, m_mode);
    chk(mode_data == m_mdata, "R2", "mode data", mode_data, m_mdata);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] modes[7] = '{8'd0, 8'd1, 8'd2, 8'd3, 8'd4, 8'd6, 8'd10};
    void'($urandom(32'd20517));
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!rsp_valid && !out_valid && mode == 0 && mode_data == 0, "R4", "reset state",
        {rsp_valid, out_valid, mode}, 0);

    // directed corners
    send_blk(1, 0, 0);                    // R5 data before header
    send_blk(0, 2, 0);                    // R8 enter download, mode 2
    data_len = 5;  send_blk(1, 0, 0);     // R6 fixed 128 in mode 2
    send_blk(0, 0, 0);                    // R5 header during download
    send_blk(1, 0, 1);                    // R3 checksum error, state kept
    send_blk(2, 0, 0);                    // R8 back to header wait
    prot_active = 1;
    send_blk(0, 0, 0);                    // R7 refused
    send_blk(0, 3, 0);                    // R7 mode 3 allowed
    prot_active = 0;
    send_blk(0, 0, 0);
    data_len = 0;   send_blk(1, 0, 0);    // R6 zero -> 128
    data_len = 200; send_blk(1, 0, 0);    // R6 above max -> 128
    data_len = 1;   send_blk(1, 0, 0);    // R6 single byte
    send_blk(2, 0, 0);
    send_blk(0, 4, 0);                    // R8 erase state
    send_blk(1, 0, 0);                    // R5 data during erase
    send_blk(2, 0, 0);

    // R1 invalid type byte
    rq.delete();
    send_byte(8'h07);
    repeat (2) @(negedge clk);
    chk(rq.size() == 1 && rq[0] == 8'hFF, "R1", "invalid type", rq.size() ? rq[0] : 0, 8'hFF);

    // R10 stalled header is dropped silently
    rq.delete();
    send_byte(8'h00); send_byte(8'h01); send_byte(8'h22);
    repeat (TMO + 10) @(negedge clk);
    chk(rq.size() == 0, "R10", "no response after stall", rq.size(), 0);
    send_blk(0, 1, 0);

    // constrained random
    for (int it = 0; it < 260; it++) begin
      int r = $urandom % 10;
      prot_active = ($urandom % 4 == 0);
      data_len = ($urandom % 8 == 0) ? 8'($urandom) : 8'(1 + $urandom % 40);
      if (r < 3) send_blk(0, modes[$urandom % 7], ($urandom % 6 == 0));
      else if (r < 7) send_blk(1, 0, ($urandom % 6 == 0));
      else if (r < 9) send_blk(2, 0, ($urandom % 6 == 0));
      else begin
        rq.delete();
        send_byte(8'(3 + $urandom % 253));
        repeat (2) @(negedge clk);
        chk(rq.size() == 1 && rq[0] == 8'hFF, "R1", "random invalid type",
            rq.size() ? rq[0] : 0, 8'hFF);
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule